// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is one input channel of a serial audio port. It watches an external bit clock, a frame-sync (word-select) line and a serial data line. It turns the bit stream into 32-bit parallel samples. Each sample comes out with a one-cycle valid strobe and a flag that says whether it belongs to the left or the right half of the frame. The three external lines pass through a synchronizer into the system clock domain. All framing decisions are taken on the rising edges of the bit clock that the synchronizer detects.

A 3-bit format code picks one of eight framings:

- Left-justified or I2S at 24 bits, capturing both halves of every frame.
- Left-justified or I2S at 32 bits.
- Right-justified at 24, 20, 18 or 16 bits.

Every captured sample is left-aligned in the output word, and the unused low bits are zero. A half-frame that ends before a full sample has arrived produces no strobe. A full port is eight copies of this block, with their format codes packed side by side and channel 0 in the lowest three bits.

Top module: `sai_rx`

## Requirements
- R1: After a synchronous reset, `smp_valid` is 0 and `smp_data` is all zeros, and both stay so until a sample completes.
- R2: Format code 3'b000 (left-justified pair) captures 24 bits per half-frame. The MSB is the bit sampled on the first bit-clock rise at which a frame-sync change is seen. A high frame sync marks the left half.
- R3: Format code 3'b001 (I2S pair) captures 24 bits per half-frame. The MSB is sampled one bit-clock rise later than in R2. A low frame sync marks the left half.
- R4: Format code 3'b010 captures 32-bit left-justified samples, with the same alignment and polarity as R2.
- R5: Format code 3'b011 captures 32-bit I2S samples, with the same alignment and polarity as R3. The LSB of a sample may be the bit sampled on the first rise of the next half-frame.
- R6: Format codes 3'b100, 3'b101, 3'b110 and 3'b111 are right-justified with 24, 20, 18 and 16 bits. The sample is the last W bits received before the next frame-sync change, and a high frame sync marks the left half.
- R7: A sample of W bits appears in `smp_data[31:32-W]`, MSB first, and `smp_data[31-W:0]` is zero.
- R8: A half-frame with fewer bits than the selected width produces no valid strobe. The first half-frame after reset, which has no preceding frame-sync change, also produces none.
- R9: `smp_valid` is a single-cycle pulse, one per completed half-frame, in arrival order. In the pair formats the left sample is followed by the right sample of the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 3 | Framing format code, held stable while receiving |
| bclk_in | input | 1 | External serial bit clock |
| wsel_in | input | 1 | External frame-sync / word-select line |
| sdat_in | input | 1 | External serial data line |
| smp_data | output | 32 | Left-aligned received sample |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |
| smp_left | output | 1 | 1 when the sample belongs to the left half-frame |

## Verification
Every format code is driven with a stream of six half-frames carrying distinct words.

Half-frames of 32 bits show that each format keeps the correct end of a longer stream: the leading bits for the justified-left and I2S framings, the trailing bits for the right-justified ones. Half-frames of exactly the sample width separate the one-bit I2S offset from the left-justified alignment, because a bit that is off by one position changes the word. Half-frames one bit short of the width must produce no strobe, while their neighbours still arrive with the correct left/right flags.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

  localparam int SAMPLE_W = 32;
  localparam int CNT_W    = $clog2(SAMPLE_W + 1);

  typedef enum logic [2:0] {
    FMT_LJ_PAIR  = 3'd0,
    FMT_I2S_PAIR = 3'd1,
    FMT_LJ_32    = 3'd2,
    FMT_I2S_32   = 3'd3,
    FMT_RJ_24    = 3'd4,
    FMT_RJ_20    = 3'd5,
    FMT_RJ_18    = 3'd6,
    FMT_RJ_16    = 3'd7
  } fmt_e;

  // Number of bits kept for one sample in a given format.
  function automatic logic [CNT_W-1:0] fmt_width(input logic [2:0] code);
    case (fmt_e'(code))
      FMT_LJ_PAIR, FMT_I2S_PAIR, FMT_RJ_24: fmt_width = CNT_W'(24);
      FMT_LJ_32, FMT_I2S_32:                fmt_width = CNT_W'(32);
      FMT_RJ_20:                            fmt_width = CNT_W'(20);
      FMT_RJ_18:                            fmt_width = CNT_W'(18);
      default:                              fmt_width = CNT_W'(16);
    endcase
  endfunction

  function automatic logic fmt_is_rj(input logic [2:0] code);
    fmt_is_rj = code[2];
  endfunction

  function automatic logic fmt_is_i2s(input logic [2:0] code);
    fmt_is_i2s = !code[2] && code[0];
  endfunction

endpackage

// File: rtl/sai_rx_sync.sv
module sai_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic wsel_i,
  input  logic sdat_i,
  output logic tick_o,
  output logic wsel_o,
  output logic sdat_o
);

  localparam int LINES = 3;

  logic [LINES-1:0] stage_q [STAGES];
  logic             bclk_last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= {bclk_i, wsel_i, sdat_i};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_last_q <= 1'b0;
      tick_o      <= 1'b0;
      wsel_o      <= 1'b0;
      sdat_o      <= 1'b0;
    end else begin
      bclk_last_q <= stage_q[STAGES-1][2];
      tick_o      <= stage_q[STAGES-1][2] & ~bclk_last_q;
      wsel_o      <= stage_q[STAGES-1][1];
      sdat_o      <= stage_q[STAGES-1][0];
    end
  end

endmodule

// File: rtl/sai_rx_frame.sv
module sai_rx_frame
  import sai_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          fmt,
  input  logic                tick,
  input  logic                wsel,
  input  logic                sdat,
  output logic                done_o,
  output logic [SAMPLE_W-1:0] word_o,
  output logic [CNT_W-1:0]    width_o,
  output logic                left_o
);

  logic                wsel_prev_q;
  logic                primed_q;
  logic                synced_q;
  logic                active_q;
  logic                side_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SAMPLE_W-1:0] shreg_q;

  logic                edge_seen;
  logic [CNT_W-1:0]    need;
  logic [CNT_W-1:0]    cnt_inc;
  logic [SAMPLE_W-1:0] shifted;
  logic [SAMPLE_W-1:0] first_bit;

  always_comb begin
    edge_seen = primed_q && (wsel != wsel_prev_q);
    need      = fmt_width(fmt);
    cnt_inc   = cnt_q + CNT_W'(1);
    shifted   = {shreg_q[SAMPLE_W-2:0], sdat};
    first_bit = {{(SAMPLE_W-1){1'b0}}, sdat};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel_prev_q <= 1'b0;
      primed_q    <= 1'b0;
      synced_q    <= 1'b0;
      active_q    <= 1'b0;
      side_q      <= 1'b0;
      cnt_q       <= '0;
      shreg_q     <= '0;
      done_o      <= 1'b0;
      word_o      <= '0;
      width_o     <= '0;
      left_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick) begin
        wsel_prev_q <= wsel;
        primed_q    <= 1'b1;
        if (fmt_is_rj(fmt)) begin
          // Right-justified: shift everything, keep the tail at the boundary.
          if (edge_seen) begin
            if (synced_q && cnt_q >= need) begin
              done_o  <= 1'b1;
              word_o  <= shreg_q;
              width_o <= need;
              left_o  <= wsel_prev_q;
            end
            synced_q <= 1'b1;
            shreg_q  <= first_bit;
            cnt_q    <= CNT_W'(1);
          end else begin
            shreg_q <= shifted;
            if (cnt_q != CNT_W'(SAMPLE_W)) cnt_q <= cnt_inc;
          end
        end else if (edge_seen) begin
          if (fmt_is_i2s(fmt)) begin
            // The bit at the boundary may still be the previous sample's LSB.
            if (active_q && cnt_inc == need) begin
              done_o  <= 1'b1;
              word_o  <= shifted;
              width_o <= need;
              left_o  <= side_q;
            end
            active_q <= 1'b1;
            cnt_q    <= '0;
            shreg_q  <= '0;
            side_q   <= ~wsel;
          end else begin
            // Left-justified: the boundary bit is the new MSB; any
            // unfinished capture is dropped.
            active_q <= 1'b1;
            cnt_q    <= CNT_W'(1);
            shreg_q  <= first_bit;
            side_q   <= wsel;
          end
        end else if (active_q) begin
          shreg_q <= shifted;
          cnt_q   <= cnt_inc;
          if (cnt_inc == need) begin
            done_o   <= 1'b1;
            word_o   <= shifted;
            width_o  <= need;
            left_o   <= side_q;
            active_q <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sai_rx_pack.sv
module sai_rx_pack
  import sai_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                done_i,
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic [CNT_W-1:0]    width_i,
  input  logic                left_i,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                valid_o,
  output logic                left_o
);

  logic [CNT_W-1:0] shamt;

  always_comb shamt = CNT_W'(SAMPLE_W) - width_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      left_o  <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        data_o <= word_i << shamt;
        left_o <= left_i;
      end
    end
  end

endmodule

// File: rtl/sai_rx.sv
module sai_rx
  import sai_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          fmt,
  input  logic                bclk_in,
  input  logic                wsel_in,
  input  logic                sdat_in,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_valid,
  output logic                smp_left
);

  logic                bit_tick;
  logic                wsel_s;
  logic                sdat_s;
  logic                cap_done;
  logic [SAMPLE_W-1:0] cap_word;
  logic [CNT_W-1:0]    cap_width;
  logic                cap_left;

  sai_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .bclk_i (bclk_in),
    .wsel_i (wsel_in),
    .sdat_i (sdat_in),
    .tick_o (bit_tick),
    .wsel_o (wsel_s),
    .sdat_o (sdat_s)
  );

  sai_rx_frame u_frame (
    .clk     (clk),
    .rst     (rst),
    .fmt     (fmt),
    .tick    (bit_tick),
    .wsel    (wsel_s),
    .sdat    (sdat_s),
    .done_o  (cap_done),
    .word_o  (cap_word),
    .width_o (cap_width),
    .left_o  (cap_left)
  );

  sai_rx_pack u_pack (
    .clk     (clk),
    .rst     (rst),
    .done_i  (cap_done),
    .word_i  (cap_word),
    .width_i (cap_width),
    .left_i  (cap_left),
    .data_o  (smp_data),
    .valid_o (smp_valid),
    .left_o  (smp_left)
  );

endmodule

// File: rtl/sai_rx_chk.sv
module sai_rx_chk
  import sai_rx_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [2:0]          fmt,
  input logic                tick,
  input logic                valid,
  input logic [SAMPLE_W-1:0] data
);

  logic [SAMPLE_W-1:0] low_mask;

  always_comb low_mask = {SAMPLE_W{1'b1}} >> fmt_width(fmt);

  // R1: reset clears the strobe and the data word
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!valid && data == '0));

  // R9: the strobe never lasts two cycles
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R9: every strobe traces back to a bit-clock rise two cycles earlier
  assert_valid_after_tick_R9: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(tick, 2));

  // R7: bits below the sample width are zero
  assert_low_bits_zero_R7: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((data & low_mask) == '0));

endmodule

bind sai_rx sai_rx_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .fmt   (fmt),
  .tick  (bit_tick),
  .valid (smp_valid),
  .data  (smp_data)
);

// File: tb/tb_sai_rx.sv
module tb_sai_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  fmt = 3'd0;
  logic        bclk_in = 1'b0;
  logic        wsel_in = 1'b0;
  logic        sdat_in = 1'b0;
  logic [31:0] smp_data;
  logic        smp_valid;
  logic        smp_left;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [31:0] got_data [64];
  logic        got_left [64];
  int          got_n = 0;
  logic [31:0] exp_data [64];
  logic        exp_left [64];
  int          exp_n = 0;

  always #2.5 clk = ~clk;

  sai_rx dut (
    .clk       (clk),
    .rst       (rst),
    .fmt       (fmt),
    .bclk_in   (bclk_in),
    .wsel_in   (wsel_in),
    .sdat_in   (sdat_in),
    .smp_data  (smp_data),
    .smp_valid (smp_valid),
    .smp_left  (smp_left)
  );

  always @(negedge clk) begin
    if (!rst && smp_valid && got_n < 64) begin
      got_data[got_n] = smp_data;
      got_left[got_n] = smp_left;
      got_n++;
    end
  end

  function automatic int width_of(input int m);
    case (m)
      0, 1, 4: return 24;
      2, 3:    return 32;
      5:       return 20;
      6:       return 18;
      default: return 16;
    endcase
  endfunction

  function automatic string req_of(input int m);
    case (m)
      0:       return "R2";
      1:       return "R3";
      2:       return "R4";
      3:       return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic ws, input logic d);
    @(negedge clk);
    bclk_in = 1'b0;
    wsel_in = ws;
    sdat_in = d;
    repeat (4) @(negedge clk);
    bclk_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input int m);
    @(negedge clk);
    rst = 1'b1;
    fmt = 3'(m);
    bclk_in = 1'b0;
    wsel_in = 1'b0;
    sdat_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {31'd0, smp_valid}, 0);
    check("R1", smp_data, 0);
    got_n = 0;
    exp_n = 0;
  endtask

  // Six half-frames with the given bit counts, then a short tail half.
  task automatic run_case(input int m, input int run, input int b0, input int b1,
                          input int b2, input int b3, input int b4, input int b5);
    int     blen [6];
    int     w;
    bit     i2s, rj;
    logic   first_lvl;
    logic   prev_bit;
    logic   lvl;
    longint unsigned word, wmask;
    blen = '{b0, b1, b2, b3, b4, b5};
    w    = width_of(m);
    i2s  = (m == 1 || m == 3);
    rj   = (m >= 4);
    first_lvl = i2s ? 1'b0 : 1'b1;
    prev_bit  = 1'b0;
    do_reset(m);
    // lead-in half without a preceding frame-sync change (R8)
    for (int i = 0; i < 3; i++) begin
      bit_out(~first_lvl, prev_bit);
    end
    for (int h = 0; h < 6; h++) begin
      lvl   = first_lvl ^ logic'(h & 1);
      word  = longint'(32'h9E3779B9 * (run * 8 + h + 1) ^ 32'h5A5A0F0F);
      wmask = (64'd1 << blen[h]) - 1;
      word  = word & wmask;
      for (int i = 0; i < blen[h]; i++) begin
        logic b;
        b = word[blen[h] - 1 - i];
        bit_out(lvl, i2s ? prev_bit : b);
        prev_bit = b;
      end
      if (blen[h] >= w) begin
        if (rj) exp_data[exp_n] = 32'((word & ((64'd1 << w) - 1)) << (32 - w));
        else    exp_data[exp_n] = 32'(((word >> (blen[h] - w)) & ((64'd1 << w) - 1)) << (32 - w));
        exp_left[exp_n] = (h % 2 == 0);
        exp_n++;
      end
    end
    lvl = first_lvl ^ 1'b0;
    for (int i = 0; i < 3; i++) begin
      bit_out(lvl, i2s ? prev_bit : 1'b0);
      prev_bit = 1'b0;
    end
    repeat (20) @(negedge clk);
    // R8: short half-frames give no strobe; R9: one strobe per full half
    check(exp_n < 6 ? "R8" : "R9", got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      check(req_of(m), got_data[k], exp_data[k]);   // value and R7 alignment
      check("R9", {31'd0, got_left[k]}, {31'd0, exp_left[k]});
    end
  endtask

  initial begin
    for (int m = 0; m < 8; m++) begin
      int w;
      w = width_of(m);
      run_case(m, 2 * m, 32, 32, 32, 32, 32, 32);
      run_case(m, 2 * m + 1, w, w, w - 1, w, 31, w);
    end
    run_case(0, 40, 23, 24, 30, 10, 24, 25);
    run_case(5, 41, 19, 20, 32, 21, 2, 20);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule